// File: doc/BRIEF.md
# Pin Data, Direction and Pull Register Block

This block holds the output latches, drive enables and pull-resistor controls for a bank of up to fifty general-purpose pins. Software reaches it through a 16-bit register port with byte offsets. Each pin's output value and drive enable go to the pad, and the pad input level can be read back. A write takes effect at the next clock edge. A read strobe loads the read-data register at the next edge, and that register holds its value until the next strobe.

Two parameters choose the variant. `PIN_COUNT` is 36, 48 or 50. `UPPER_OE` chooses how pins 32 and up get their drive enables. When `UPPER_OE` is clear, pins 32 to 47 always drive their latch. Pins 48 and 49 then take their enables from bits 8 and 9 of the register that also holds their data. When `UPPER_OE` is set, offset 0x01C is a per-pin enable register for pins 32 to 47, and their data moves to offset 0x01E. Pull resistors exist only when `PIN_COUNT` is 50, and only for pins 0 to 14.

The block does not use a sequencer. Every register captures directly on the clock edge where it is written, and no other state exists.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset all latches, enables, pull controls and `reg_rdata` are 0. The only exception is output-only pins (32 to 47 when `UPPER_OE` is 0), which drive from reset with `pad_oe` = 1 and `pad_out` = 0.
- R2: Bit n of offset 0x000 is the drive enable of pin n, and bit n of offset 0x002 is the enable of pin 16+n. A 1 means output. `pad_oe` follows at the edge that performs the write.
- R3: Bit n of offset 0x004 is the output latch of pin n, and bit n of offset 0x006 is the latch of pin 16+n. `pad_out` follows at the edge that performs the write.
- R4: A data-register bit reads the latch when its pin drives and reads the sampled `pad_in` otherwise. Read data is loaded at the edge where `reg_rd` is high and holds until the next read.
- R5: When `UPPER_OE` is 0, bit n of 0x01C is the latch of output-only pin 32+n. In 0x01E, bits 0 and 1 are the latches of pins 48 and 49, and bits 8 and 9 are their enables.
- R6: When `UPPER_OE` is 1, bit n of 0x01C is the enable of pin 32+n and bit n of 0x01E is its latch.
- R7: When `PIN_COUNT` is 50, bit n of 0x1E0 turns on the pull of pin n (`pull_en`). Bit n of 0x1E2 picks pull-up with 1 and pull-down with 0 (`pull_up`). Both apply to n = 0 to 14, and bit 15 reads 0. On other variants both registers read 0 and ignore writes.
- R8: Bits with no pin behind them read 0 and ignore writes. This covers pins at or above `PIN_COUNT` and the unused bits of 0x01E.
- R9: Any offset not listed above reads 0, odd offsets included. A write to such an offset changes no output.
- R10: A read and a write to the same offset in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | 10 | Byte offset of the access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pad_in | input | PIN_COUNT | Pad input levels |
| pad_out | output | PIN_COUNT | Output latch per pin |
| pad_oe | output | PIN_COUNT | Drive enable per pin |
| pull_en | output | 15 | Pull resistor on, pins 0 to 14 |
| pull_up | output | 15 | 1 pull-up, 0 pull-down, pins 0 to 14 |

## Verification
A write is due on `pad_out`, `pad_oe`, `pull_en` and `pull_up` one rising edge after its strobe. A read is due on `reg_rdata` one rising edge after `reg_rd`, and it reflects `pad_in` as it stood at that edge. The bench changes every input on a falling edge and samples on the following falling edge, so each check lands half a cycle after the only edge that can produce its result. The hold check reads no register for several cycles while `pad_in` moves, and confirms that `reg_rdata` does not change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 10;
    localparam int NUM_REGS  = 8;
    localparam int IDX_W     = 4;
    localparam int PULL_PINS = 15;

    // register slots
    localparam int IDX_DIR_LO = 0;
    localparam int IDX_DIR_HI = 1;
    localparam int IDX_DAT_LO = 2;
    localparam int IDX_DAT_HI = 3;
    localparam int IDX_UP_A   = 4;
    localparam int IDX_UP_B   = 5;
    localparam int IDX_PUSE   = 6;
    localparam int IDX_PSEL   = 7;
    localparam int IDX_NONE   = 8;

    localparam logic [ADDR_W-1:0] OFF_DIR_LO = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_DIR_HI = 10'h002;
    localparam logic [ADDR_W-1:0] OFF_DAT_LO = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_DAT_HI = 10'h006;
    localparam logic [ADDR_W-1:0] OFF_UP_A   = 10'h01C;
    localparam logic [ADDR_W-1:0] OFF_UP_B   = 10'h01E;
    localparam logic [ADDR_W-1:0] OFF_PUSE   = 10'h1E0;
    localparam logic [ADDR_W-1:0] OFF_PSEL   = 10'h1E2;

    // drive-enable sources
    localparam int OE_REG = 0;
    localparam int OE_ON  = 1;
    localparam int OE_OFF = 2;

    function automatic int dat_reg(input int pin, input bit upper_oe);
        if (pin < 16)      return IDX_DAT_LO;
        else if (pin < 32) return IDX_DAT_HI;
        else if (pin < 48) return upper_oe ? IDX_UP_B : IDX_UP_A;
        else               return upper_oe ? IDX_NONE : IDX_UP_B;
    endfunction

    function automatic int dat_bit(input int pin);
        if (pin < 48) return pin % 16;
        else          return pin - 48;
    endfunction

    function automatic int oe_mode(input int pin, input bit upper_oe);
        if (pin < 32)      return OE_REG;
        else if (pin < 48) return upper_oe ? OE_REG : OE_ON;
        else               return upper_oe ? OE_OFF : OE_REG;
    endfunction

    function automatic int oe_reg(input int pin);
        if (pin < 16)      return IDX_DIR_LO;
        else if (pin < 32) return IDX_DIR_HI;
        else if (pin < 48) return IDX_UP_A;
        else               return IDX_UP_B;
    endfunction

    function automatic int oe_bit(input int pin);
        if (pin < 32)      return pin % 16;
        else if (pin < 48) return pin - 32;
        else               return 8 + pin - 48;
    endfunction
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_port_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        hit = 1'b1;
        idx = IDX_W'(IDX_NONE);
        case (addr)
            OFF_DIR_LO: idx = IDX_W'(IDX_DIR_LO);
            OFF_DIR_HI: idx = IDX_W'(IDX_DIR_HI);
            OFF_DAT_LO: idx = IDX_W'(IDX_DAT_LO);
            OFF_DAT_HI: idx = IDX_W'(IDX_DAT_HI);
            OFF_UP_A:   idx = IDX_W'(IDX_UP_A);
            OFF_UP_B:   idx = IDX_W'(IDX_UP_B);
            OFF_PUSE:   idx = IDX_W'(IDX_PUSE);
            OFF_PSEL:   idx = IDX_W'(IDX_PSEL);
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic dat_we,
    input  logic dat_wbit,
    input  logic oe,
    input  logic pad_in,
    output logic pad_out,
    output logic rd_bit
);
    logic latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      latch_q <= 1'b0;
        else if (dat_we) latch_q <= dat_wbit;
    end

    assign pad_out = latch_q;
    assign rd_bit  = oe ? latch_q : pad_in;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 50,
    parameter bit UPPER_OE  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PULL_PINS-1:0] pull_en,
    output logic [PULL_PINS-1:0] pull_up
);
    localparam bit PULL_ON = (PIN_COUNT == 50);

    logic                            hit;
    logic [IDX_W-1:0]                idx;
    logic                            wr_go;
    logic [PIN_COUNT-1:0]            rd_bit;
    logic [NUM_REGS-1:0][REG_W-1:0]  rd_words;

    gpio_reg_decode u_dec (
        .addr (reg_addr),
        .hit  (hit),
        .idx  (idx)
    );

    assign wr_go = reg_wr & hit;

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        localparam int DR = dat_reg(p, UPPER_OE);
        localparam int DB = dat_bit(p);
        localparam int OM = oe_mode(p, UPPER_OE);
        localparam int OR = oe_reg(p);
        localparam int OB = oe_bit(p);

        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .dat_we   (wr_go && (idx == IDX_W'(DR))),
            .dat_wbit (reg_wdata[DB]),
            .oe       (pad_oe[p]),
            .pad_in   (pad_in[p]),
            .pad_out  (pad_out[p]),
            .rd_bit   (rd_bit[p])
        );

        if (OM == OE_REG) begin : g_oe_reg
            logic oe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                            oe_q <= 1'b0;
                else if (wr_go && (idx == IDX_W'(OR))) oe_q <= reg_wdata[OB];
            end
            assign pad_oe[p] = oe_q;
        end else if (OM == OE_ON) begin : g_oe_on
            assign pad_oe[p] = 1'b1;
        end else begin : g_oe_off
            assign pad_oe[p] = 1'b0;
        end
    end

    if (PULL_ON) begin : g_pull
        logic [PULL_PINS-1:0] use_q, sel_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                use_q <= '0;
                sel_q <= '0;
            end else if (wr_go) begin
                if (idx == IDX_W'(IDX_PUSE)) use_q <= reg_wdata[PULL_PINS-1:0];
                if (idx == IDX_W'(IDX_PSEL)) sel_q <= reg_wdata[PULL_PINS-1:0];
            end
        end
        assign pull_en = use_q;
        assign pull_up = sel_q;
    end else begin : g_nopull
        assign pull_en = '0;
        assign pull_up = '0;
    end

    // assemble every readable word from the per-pin maps
    always_comb begin
        rd_words = '0;
        for (int p = 0; p < PIN_COUNT; p++) begin
            if (dat_reg(p, UPPER_OE) != IDX_NONE)
                rd_words[dat_reg(p, UPPER_OE)][dat_bit(p)] = rd_bit[p];
            if (oe_mode(p, UPPER_OE) == OE_REG)
                rd_words[oe_reg(p)][oe_bit(p)] = pad_oe[p];
        end
        rd_words[IDX_PUSE] = {1'b0, pull_en};
        rd_words[IDX_PSEL] = {1'b0, pull_up};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= hit ? rd_words[idx[2:0]] : '0;
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 50,
    parameter bit UPPER_OE  = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic [PULL_PINS-1:0] pull_en,
    input logic [PULL_PINS-1:0] pull_up
);
    logic listed;
    assign listed = (reg_addr == 10'h000) || (reg_addr == 10'h002) ||
                    (reg_addr == 10'h004) || (reg_addr == 10'h006) ||
                    (reg_addr == 10'h01C) || (reg_addr == 10'h01E) ||
                    (reg_addr == 10'h1E0) || (reg_addr == 10'h1E2);

    // R2
    dir_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe[0]) |-> $past(reg_wr && reg_addr == 10'h000 && reg_wdata[0]));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(pad_out));

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R7
    pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(pull_en) && $stable(pull_up)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !listed) |=> (reg_rdata == '0));

    if (!UPPER_OE) begin : g_upb
        // R8
        upb_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == 10'h01E) |=> ((reg_rdata & 16'hFCFC) == '0));
    end
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .PIN_COUNT (PIN_COUNT),
    .UPPER_OE  (UPPER_OE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pull_en   (pull_en),
    .pull_up   (pull_up)
);

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata0, rdata1;
    logic [49:0] pad0 = '0, out0, oe0;
    logic [47:0] pad1 = '0, out1, oe1;
    logic [14:0] pen0, pup0, pen1, pup1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_regs #(.PIN_COUNT(50), .UPPER_OE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr0), .reg_rd(rd0), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata0), .pad_in(pad0), .pad_out(out0),
        .pad_oe(oe0), .pull_en(pen0), .pull_up(pup0));

    gpio_port_regs #(.PIN_COUNT(48), .UPPER_OE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_rd(rd1), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata1), .pad_in(pad1), .pad_out(out1),
        .pad_oe(oe1), .pull_en(pen1), .pull_up(pup1));

    // models
    logic [31:0] m_dir = '0;
    logic [49:0] m_dat = '0;
    logic [1:0]  m_oeh = '0;
    logic [14:0] m_use = '0, m_sel = '0;
    logic [31:0] n_dir = '0;
    logic [47:0] n_dat = '0;
    logic [15:0] n_oe  = '0;

    function automatic logic [15:0] mix(input logic [15:0] o, input logic [15:0] l,
                                        input logic [15:0] p);
        return (o & l) | (~o & p);
    endfunction

    function automatic logic [15:0] exp0(input logic [9:0] a);
        case (a)
            10'h000: return m_dir[15:0];
            10'h002: return m_dir[31:16];
            10'h004: return mix(m_dir[15:0], m_dat[15:0], pad0[15:0]);
            10'h006: return mix(m_dir[31:16], m_dat[31:16], pad0[31:16]);
            10'h01C: return m_dat[47:32];
            10'h01E: return {6'b0, m_oeh, 6'b0,
                             (m_oeh & m_dat[49:48]) | (~m_oeh & pad0[49:48])};
            10'h1E0: return {1'b0, m_use};
            10'h1E2: return {1'b0, m_sel};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp1(input logic [9:0] a);
        case (a)
            10'h000: return n_dir[15:0];
            10'h002: return n_dir[31:16];
            10'h004: return mix(n_dir[15:0], n_dat[15:0], pad1[15:0]);
            10'h006: return mix(n_dir[31:16], n_dat[31:16], pad1[31:16]);
            10'h01C: return n_oe;
            10'h01E: return mix(n_oe, n_dat[47:32], pad1[47:32]);
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_wr0(input logic [9:0] a, input logic [15:0] d);
        case (a)
            10'h000: m_dir[15:0]   = d;
            10'h002: m_dir[31:16]  = d;
            10'h004: m_dat[15:0]   = d;
            10'h006: m_dat[31:16]  = d;
            10'h01C: m_dat[47:32]  = d;
            10'h01E: begin m_dat[49:48] = d[1:0]; m_oeh = d[9:8]; end
            10'h1E0: m_use = d[14:0];
            10'h1E2: m_sel = d[14:0];
            default: ;
        endcase
    endtask

    task automatic model_wr1(input logic [9:0] a, input logic [15:0] d);
        case (a)
            10'h000: n_dir[15:0]  = d;
            10'h002: n_dir[31:16] = d;
            10'h004: n_dat[15:0]  = d;
            10'h006: n_dat[31:16] = d;
            10'h01C: n_oe = d;
            10'h01E: n_dat[47:32] = d;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input int t, input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (t == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
        if (t == 0) model_wr0(a, d); else model_wr1(a, d);
    endtask

    task automatic bus_rd(input int t, input logic [9:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        if (t == 0) rd0 = 1'b1; else rd1 = 1'b1;
        @(negedge clk);
        rd0 = 1'b0; rd1 = 1'b0;
        v = (t == 0) ? rdata0 : rdata1;
    endtask

    task automatic check_pads0(input string req);
        chk(req, "pad_out", 64'(out0), 64'(m_dat));
        chk(req, "pad_oe",  64'(oe0),  64'({m_oeh, 16'hFFFF, m_dir}));
        chk(req, "pull_en", 64'(pen0), 64'(m_use));
        chk(req, "pull_up", 64'(pup0), 64'(m_sel));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [15:0] v;
    logic [9:0]  offs [8];

    initial begin
        offs[0] = 10'h000; offs[1] = 10'h002; offs[2] = 10'h004; offs[3] = 10'h006;
        offs[4] = 10'h01C; offs[5] = 10'h01E; offs[6] = 10'h1E0; offs[7] = 10'h1E2;
        pad0 = 50'h2_A5A5_3C3C_F00F;
        pad1 = 48'h1234_5678_9ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "u0 pad_oe",  64'(oe0),  64'({2'b00, 16'hFFFF, 32'h0}));
        chk("R1", "u0 pad_out", 64'(out0), 64'h0);
        chk("R1", "u0 pulls",   64'({pen0, pup0}), 64'h0);
        chk("R1", "u0 rdata",   64'(rdata0), 64'h0);
        chk("R1", "u1 pad_oe",  64'(oe1),  64'h0);

        // R2 R3 R4 R5 R7: several patterns over every listed register
        for (int k = 0; k < 6; k++) begin
            for (int r = 0; r < 8; r++) begin
                logic [15:0] d;
                d = 16'hA5C3 ^ 16'(k * 16'h1F3B) ^ 16'(r * 16'h0911);
                if (k == 0) d = 16'hFFFF;
                if (k == 1) d = 16'h0000;
                bus_wr(0, offs[r], d);
            end
            check_pads0("R2 R3 R5 R7");
            pad0 = pad0 ^ {25{2'(k) + 2'b01}} ^ 50'(k * 50'h1_2345_6789);
            for (int r = 0; r < 8; r++) begin
                bus_rd(0, offs[r], v);
                if (r == 2 || r == 3) chk("R4", "data readback", 64'(v), 64'(exp0(offs[r])));
                else if (r == 4 || r == 5) chk("R5", "upper readback", 64'(v), 64'(exp0(offs[r])));
                else if (r >= 6) chk("R7", "pull readback", 64'(v), 64'(exp0(offs[r])));
                else chk("R2", "direction readback", 64'(v), 64'(exp0(offs[r])));
            end
        end

        // R8: spare bits of the pins-48/49 register
        bus_wr(0, 10'h01E, 16'hFFFF);
        bus_rd(0, 10'h01E, v);
        chk("R8", "spare bits of 0x01E", 64'(v), 64'h0303);
        chk("R8", "pins 48/49 enabled", 64'(oe0[49:48]), 64'h3);
        bus_wr(0, 10'h1E0, 16'hFFFF);
        bus_rd(0, 10'h1E0, v);
        chk("R7", "pull bit 15 reads 0", 64'(v), 64'h7FFF);

        // R9: writes to unlisted offsets change nothing
        bus_wr(0, 10'h008, 16'hFFFF);
        bus_wr(0, 10'h005, 16'h0000);
        bus_wr(0, 10'h1E4, 16'h1234);
        bus_wr(0, 10'h3FE, 16'h0F0F);
        check_pads0("R9");

        // R9 sweep: every offset against the model
        for (int a = 0; a < 1024; a++) begin
            bus_rd(0, 10'(a), v);
            chk("R9", $sformatf("sweep offset %h", a), 64'(v), 64'(exp0(10'(a))));
        end

        // R4 hold: no read, pads move, rdata unchanged
        bus_wr(0, 10'h000, 16'h00FF);
        bus_rd(0, 10'h004, v);
        pad0 = ~pad0;
        repeat (4) @(negedge clk);
        chk("R4", "rdata holds", 64'(rdata0), 64'(v));
        bus_rd(0, 10'h004, v);
        chk("R4", "input pins resampled", 64'(v), 64'(exp0(10'h004)));

        // R10: read and write of the same offset in one cycle
        begin
            logic [15:0] old, nd;
            old = exp0(10'h000);
            nd  = ~old;
            @(negedge clk);
            addr = 10'h000; wdata = nd; wr0 = 1'b1; rd0 = 1'b1;
            @(negedge clk);
            wr0 = 1'b0; rd0 = 1'b0;
            model_wr0(10'h000, nd);
            chk("R10", "read during write", 64'(rdata0), 64'(old));
            chk("R10", "write still lands", 64'(oe0[15:0]), 64'(nd));
        end

        // R6: per-pin enables for the upper pins
        bus_wr(1, 10'h01C, 16'h0FF0);
        bus_wr(1, 10'h01E, 16'h5A5A);
        chk("R6", "u1 upper enables", 64'(oe1[47:32]), 64'h0FF0);
        chk("R6", "u1 upper latches", 64'(out1[47:32]), 64'h5A5A);
        bus_rd(1, 10'h01E, v);
        chk("R6", "u1 upper readback", 64'(v), 64'(exp1(10'h01E)));
        bus_rd(1, 10'h01C, v);
        chk("R6", "u1 enable readback", 64'(v), 64'h0FF0);
        bus_wr(1, 10'h1E0, 16'hFFFF);
        bus_rd(1, 10'h1E0, v);
        chk("R7", "u1 has no pulls", 64'(v), 64'h0);
        chk("R7", "u1 pull outputs", 64'({pen1, pup1}), 64'h0);
        chk("R6", "u0 untouched by u1 writes", 64'(oe0[47:32]), 64'hFFFF);

        finish_run();
    end
endmodule